// File: doc/BRIEF.md
# Multi-Slave SPI Master Controller

This block is the master side of a serial peripheral bus. It generates the serial clock, drives master-out data, samples master-in data, and owns one active-low select line per attached slave. A small per-slave table holds each slave's clock polarity and clock phase. The table is written through a register-write port.

A host starts a transfer with a slave index, a character length between 4 and 16 bits, and a transmit word. The block then works in a fixed order. First it loads that slave's clock mode and lets the clock line settle at the new idle level. Next it asserts the one matching select and runs a full-duplex exchange of the requested number of bits. It then waits half a bit period and releases the select. Finally it returns the received word with a one-cycle done pulse. The slave never acknowledges, so the transfer ends after its bit count whether or not anything answered. The block rejects a request that names a slave that does not exist, or a length outside 4 to 16. It flags such a request with an error pulse and causes no bus activity.

Top module: `spim_master`

## Requirements
- R1: After reset all selects are high, busy, done and err are low, the serial clock is low and the received word is zero; every stored mode resets to 0.
- R2: A request is accepted only while idle, with an index below NSLV and a length of 4 to 16. Any other request made while idle gives a one-cycle err pulse, stays idle and drives no select. An accepted request sets busy on the next cycle.
- R3: During a transfer exactly the addressed slave's select is low, and at no time is more than one select low.
- R4: A mode is two bits: bit 1 is the clock idle level (polarity) and bit 0 is the phase. Before any select falls, the serial clock already rests at the addressed slave's idle level. The applied mode does not change while a select is low.
- R5: A transfer of L bits makes exactly 2·L serial clock edges, one every DIV system cycles. The select stays low for (2·L+1)·DIV cycles, and the clock ends at its idle level.
- R6: Only the low L bits of the transmit word are sent, most significant first. With phase 0 each bit is valid from the select falling edge (first bit) or from the preceding trailing edge, and is sampled on leading edges. With phase 1 each bit is driven on a leading edge and sampled on the following trailing edge.
- R7: One master-in bit is captured at each sampling edge. The received word is right-aligned to L bits, with the bits above L cleared.
- R8: Done is a one-cycle pulse in the cycle the select rises, and the received word is valid with it.
- R9: A mode write while idle is stored for its slave. A mode write while busy has no effect on any stored mode.
- R10: A request made while busy is ignored: it starts no second transfer and produces no second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mode table write strobe |
| cfg_idx | input | IW | Slave whose mode is written |
| cfg_mode | input | 2 | Mode value {polarity, phase} |
| req_valid | input | 1 | Transfer request strobe |
| req_idx | input | IW | Target slave index |
| req_len | input | LW | Character length in bits |
| req_data | input | MAXW | Transmit word, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| rx_data | output | MAXW | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Master-out data |
| miso | input | 1 | Master-in data |
| ss_n | output | NSLV | Active-low slave selects |

## Verification
The hardest case to bring about is a change of both polarity and phase between two back-to-back transfers to different slaves. In that case the clock line has to move to a new idle level before the new select falls. Stimulus gets there with directed pairs of slaves whose modes are programmed to be opposite, and with random sequences that interleave mode writes with transfers. A bench slave model decodes leading and trailing edges from its own copy of the mode table. A second hard case is a mode write or a request that lands in the middle of a transfer. The bench injects both a few cycles after acceptance. It then shows the write had no effect by checking the idle clock level of a later transfer to that slave.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_LEAD,
    S_XFER,
    S_TRAIL
  } spim_state_e;

  // Phase 0 samples on even (leading) edges, phase 1 on odd (trailing) edges.
  function automatic logic edge_samples(input logic cpha, input int unsigned eidx);
    return cpha ? logic'(eidx % 2 == 1) : logic'(eidx % 2 == 0);
  endfunction

  function automatic logic len_in_range(input int unsigned len, input int unsigned lo,
                                        input int unsigned hi);
    return (len >= lo) && (len <= hi);
  endfunction

endpackage

// File: rtl/spim_mode_regs.sv
module spim_mode_regs #(
  parameter int NSLV = 6,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          busy,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_mode,
  input  logic [IW-1:0] rd_idx,
  output logic [1:0]    rd_mode
);
  logic [NSLV-1:0][1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_en && !busy && (int'(wr_idx) < NSLV)) begin
      mode_q[wr_idx] <= wr_mode;
    end
  end

  always_comb begin
    rd_mode = '0;
    if (int'(rd_idx) < NSLV) rd_mode = mode_q[rd_idx];
  end

  // R9: writes that arrive while busy leave the table untouched
  a_r9_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

endmodule

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int MAXW = 16,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LW-1:0]   len,
  input  logic [MAXW-1:0] tx,
  input  logic            drive,
  input  logic            sample,
  input  logic            miso,
  output logic            mosi,
  output logic [MAXW-1:0] rx
);
  logic [MAXW-1:0] tx_sr;
  logic [MAXW-1:0] rx_sr;
  logic            mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr  <= '0;
      rx_sr  <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      tx_sr  <= tx << (MAXW - int'(len));
      rx_sr  <= '0;
      mosi_q <= 1'b0;
    end else begin
      if (drive) begin
        mosi_q <= tx_sr[MAXW-1];
        tx_sr  <= tx_sr << 1;
      end
      if (sample) rx_sr <= {rx_sr[MAXW-2:0], miso};
    end
  end

  assign mosi = mosi_q;
  assign rx   = rx_sr;

  // R6: no edge both launches and captures a bit
  a_r6_drive_apart_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive, sample}));

endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int NSLV = 6,
  parameter int MAXW = 16,
  parameter int MINW = 4,
  parameter int DIV  = 2,
  parameter int IW   = (NSLV > 1) ? $clog2(NSLV) : 1,
  parameter int LW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [1:0]      cfg_mode,
  input  logic            req_valid,
  input  logic [IW-1:0]   req_idx,
  input  logic [LW-1:0]   req_len,
  input  logic [MAXW-1:0] req_data,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [MAXW-1:0] rx_data,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NSLV-1:0] ss_n
);
  localparam int EW = LW + 1;

  spim_state_e     st;
  logic [1:0]      cur_mode;
  logic [IW-1:0]   cur_idx;
  logic [LW-1:0]   len_q;
  logic [EW-1:0]   ecnt;
  logic            sclk_q, done_q, err_q;
  logic [NSLV-1:0] ss_q;
  logic [MAXW-1:0] rx_q;

  logic [1:0]      rd_mode;
  logic            tick, in_idle, req_ok, accept, reject;
  logic            edge_now, samp_edge, drv_edge;
  logic [EW-1:0]   eidx, last_e;
  logic [MAXW-1:0] rx_word;

  spim_mode_regs #(.NSLV(NSLV), .IW(IW)) u_modes (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .busy(busy),
    .wr_idx(cfg_idx), .wr_mode(cfg_mode), .rd_idx(req_idx), .rd_mode(rd_mode)
  );

  spim_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(!in_idle), .tick(tick)
  );

  assign in_idle = (st == S_IDLE);
  assign req_ok  = (int'(req_idx) < NSLV) && len_in_range(int'(req_len), MINW, MAXW);
  assign accept  = req_valid && in_idle && req_ok;
  assign reject  = req_valid && in_idle && !req_ok;

  // Edge bookkeeping: edge 0 happens on the tick that leaves S_LEAD.
  assign edge_now  = tick && ((st == S_LEAD) || (st == S_XFER));
  assign eidx      = (st == S_LEAD) ? '0 : ecnt;
  assign last_e    = {len_q, 1'b0} - EW'(1);
  assign samp_edge = edge_now && edge_samples(cur_mode[0], int'(eidx));
  assign drv_edge  = (st == S_SETUP && tick && !cur_mode[0]) ||
                     (edge_now && !edge_samples(cur_mode[0], int'(eidx)) && (eidx != last_e));

  spim_shift #(.MAXW(MAXW), .LW(LW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .len(req_len), .tx(req_data),
    .drive(drv_edge), .sample(samp_edge), .miso(miso), .mosi(mosi), .rx(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_mode <= '0;
      cur_idx  <= '0;
      len_q    <= '0;
      ecnt     <= '0;
      sclk_q   <= 1'b0;
      ss_q     <= '1;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= reject;
      unique case (st)
        S_IDLE: if (accept) begin
          st       <= S_SETUP;
          cur_mode <= rd_mode;
          sclk_q   <= rd_mode[1];
          cur_idx  <= req_idx;
          len_q    <= req_len;
        end
        S_SETUP: if (tick) begin
          st   <= S_LEAD;
          ss_q <= ~(NSLV'(1) << cur_idx);
        end
        S_LEAD: if (tick) begin
          st     <= S_XFER;
          sclk_q <= ~sclk_q;
          ecnt   <= EW'(1);
        end
        S_XFER: if (tick) begin
          sclk_q <= ~sclk_q;
          ecnt   <= ecnt + EW'(1);
          if (ecnt == last_e) st <= S_TRAIL;
        end
        S_TRAIL: if (tick) begin
          st     <= S_IDLE;
          ss_q   <= '1;
          done_q <= 1'b1;
          rx_q   <= rx_word;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = !in_idle;
  assign done    = done_q;
  assign err     = err_q;
  assign rx_data = rx_q;
  assign sclk    = sclk_q;
  assign ss_n    = ss_q;

  // R3: never more than one slave selected
  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_q));
  // R4: applied mode frozen while a select is low
  a_r4_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ss_q) |=> $stable(cur_mode));
  // R4: clock rests at idle level around the select edges
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP || st == S_LEAD || st == S_TRAIL) |-> (sclk_q == cur_mode[1]));
  // R8: done lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R2: a rejection leaves the bus quiet
  a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (in_idle && (&ss_q)));
  // R7: bits above the programmed length are zero
  a_r7_rx_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((rx_q >> len_q) == '0));

endmodule

// File: tb/spim_master_tb.sv
module spim_master_tb;
  localparam int NSLV = 6, MAXW = 16, DIV = 2, IW = 3, LW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, cfg_we, req_valid, miso;
  logic [IW-1:0]   cfg_idx, req_idx;
  logic [1:0]      cfg_mode;
  logic [LW-1:0]   req_len;
  logic [MAXW-1:0] req_data, rx_data;
  logic            busy, done, err, sclk, mosi;
  logic [NSLV-1:0] ss_n;

  spim_master #(.NSLV(NSLV), .MAXW(MAXW), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode),
    .req_valid(req_valid), .req_idx(req_idx), .req_len(req_len), .req_data(req_data),
    .busy(busy), .done(done), .err(err), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int n_chk = 0, n_fail = 0;
  logic [1:0] bm [NSLV];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [MAXW-1:0] lowbits(input logic [MAXW-1:0] w, input int len);
    return w & ((MAXW'(1) << len) - MAXW'(1));
  endfunction

  // Bench slave model
  int              exp_len = 4;
  logic [1:0]      exp_mode = 2'b00;
  logic [MAXW-1:0] exp_miso = '0;
  logic [MAXW-1:0] cap;
  int              nbits, nedges, low_cycles, falls = 0;
  logic [NSLV-1:0] sel_got;
  logic            fall_sclk, prev_sclk = 1'b0;
  logic [NSLV-1:0] prev_ss = '1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ss == '1 && ss_n != '1) begin
        falls++;
        sel_got   = ~ss_n;
        fall_sclk = sclk;
        nedges = 0; nbits = 0; cap = '0; low_cycles = 0;
        miso = exp_miso[exp_len-1];
      end
      if (ss_n != '1) begin
        low_cycles++;
        if (sclk != prev_sclk) begin
          bit lead, samp;
          nedges++;
          lead = (prev_sclk == exp_mode[1]);
          samp = exp_mode[0] ? !lead : lead;
          if (samp) begin
            cap = {cap[MAXW-2:0], mosi};
            nbits++;
            if (nbits < exp_len) miso = exp_miso[exp_len-1-nbits];
          end
        end
      end
      prev_sclk = sclk;
      prev_ss   = ss_n;
    end
  end

  task automatic cfg(input int idx, input logic [1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < NSLV) bm[idx] = m;
  endtask

  // inj: 0 none, 1 mode write mid-transfer, 2 request mid-transfer
  task automatic xfer(input int idx, input int len, input logic [MAXW-1:0] tx,
                      input logic [MAXW-1:0] mw, input int inj);
    int f0, w;
    bit got;
    exp_len = len; exp_mode = bm[idx]; exp_miso = mw;
    f0 = falls;
    @(negedge clk);
    req_valid = 1'b1; req_idx = IW'(idx); req_len = LW'(len); req_data = tx;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    got = 0;
    for (w = 0; w < 2000 && !got; w++) begin
      if (w == 6 && inj == 1) begin
        cfg_we = 1'b1; cfg_idx = IW'((idx + 1) % NSLV); cfg_mode = ~bm[(idx + 1) % NSLV];
      end else if (w == 6 && inj == 2) begin
        req_valid = 1'b1; req_idx = IW'((idx + 2) % NSLV); req_len = 5'd4;
      end else begin
        cfg_we = 1'b0; req_valid = 1'b0;
      end
      @(negedge clk);
      if (done) got = 1;
    end
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(got, "R8", "done seen", got, 1);
    chk(ss_n == '1, "R8", "select released with done", ss_n, '1);
    chk(rx_data == lowbits(mw, len), "R7", "received word", rx_data, lowbits(mw, len));
    chk(cap == lowbits(tx, len), "R6", "bits seen by slave", cap, lowbits(tx, len));
    chk(nedges == 2 * len, "R5", "clock edge count", nedges, 2 * len);
    chk(low_cycles == (2 * len + 1) * DIV, "R5", "select low cycles", low_cycles,
        (2 * len + 1) * DIV);
    chk(sel_got == NSLV'(1) << idx, "R3", "selected slave", sel_got, NSLV'(1) << idx);
    chk(fall_sclk == bm[idx][1], "R4", "clock idle at select fall", fall_sclk, bm[idx][1]);
    chk(sclk == bm[idx][1], "R5", "clock back at idle", sclk, bm[idx][1]);
    chk(falls == f0 + 1, "R3", "one select fall", falls, f0 + 1);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
    if (inj == 2) begin
      repeat (12) @(negedge clk);
      chk(busy == 1'b0 && falls == f0 + 1, "R10", "request while busy ignored", falls, f0 + 1);
    end
  endtask

  task automatic bad_req(input int idx, input int len);
    int f0;
    f0 = falls;
    @(negedge clk);
    req_valid = 1'b1; req_idx = IW'(idx); req_len = LW'(len); req_data = 16'hFFFF;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1, "R2", "err pulse", err, 1);
    chk(busy == 1'b0 && ss_n == '1, "R2", "no activity on reject", ss_n, '1);
    @(negedge clk);
    chk(err == 1'b0, "R2", "err one cycle", err, 0);
    repeat (4) @(negedge clk);
    chk(falls == f0, "R2", "no select after reject", falls, f0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 1'b0; req_valid = 1'b0; miso = 1'b0;
    cfg_idx = '0; cfg_mode = '0; req_idx = '0; req_len = '0; req_data = '0;
    for (int i = 0; i < NSLV; i++) bm[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ss_n == '1, "R1", "selects high", ss_n, '1);
    chk(!busy && !done && !err, "R1", "status low", {busy, done, err}, 0);
    chk(sclk == 1'b0, "R1", "clock low", sclk, 0);
    chk(rx_data == '0, "R1", "rx zero", rx_data, 0);
    xfer(3, 8, 16'h00A5, 16'h003C, 0);  // R1: reset mode 0 in use

    // All four modes at both length limits
    for (int m = 0; m < 4; m++) begin
      cfg(0, 2'(m));
      xfer(0, 4, 16'hFFF9, 16'h0006, 0);
      xfer(0, 16, 16'hA5C3, 16'h5A3C, 0);
    end

    // Back-to-back slaves with opposite modes (R4)
    cfg(1, 2'b11); cfg(2, 2'b00);
    xfer(1, 12, 16'h0F0F, 16'hF123, 0);
    xfer(2, 12, 16'hF0F0, 16'h0ABC, 0);
    cfg(4, 2'b01); cfg(5, 2'b10);
    xfer(4, 7, 16'h0055, 16'h002A, 0);
    xfer(5, 9, 16'h01AA, 16'h0155, 0);

    // R9: write while busy has no effect; R10: request while busy ignored
    xfer(1, 10, 16'h0333, 16'h0222, 1);
    xfer(2, 10, 16'h0111, 16'h0244, 0);
    xfer(3, 6, 16'h0015, 16'h002A, 2);

    // R2 rejections
    bad_req(6, 8);
    bad_req(7, 8);
    bad_req(0, 3);
    bad_req(0, 17);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(0, 2) == 0) cfg($urandom_range(0, NSLV - 1), 2'($urandom_range(0, 3)));
      xfer($urandom_range(0, NSLV - 1), $urandom_range(4, 16), 16'($urandom),
           16'($urandom), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule